// File: doc/BRIEF.md
# Backlight Command Register Bank

This block is the register file behind a byte-oriented SMBus-style target for a lamp backlight controller. A transaction decoder in front of it has already parsed the bus phases. It delivers a command-byte strobe, a data-byte write strobe and a read strobe. The block answers each read with one registered byte. It holds a 5-bit brightness code and a 3-bit shutdown-mode setting. It also gives read-only views of two fault flags, which a separate fault monitor supplies, and two fixed identification bytes.

The brightness code can be reached through three command bytes, each with its own bit placement. The block keeps the last command byte it received as a pointer. A read or write that arrives without a command phase then goes to the register that the pointer selects. This supports the short send-byte and receive-byte protocols. The registered brightness, shutdown-mode and pointer values leave the block on dedicated ports for the dimming and shutdown logic. The register path does not depend on whether the lamp is shut down.

Top module: `blr_top`

## Requirements
- R1: After reset, brightness is 5'b10111, shutdown mode is 3'b001, the command pointer is 0xA9 and rd_valid is 0.
- R2: Command 0x01 writes brightness from data bits 4:0. A read through 0x01 returns brightness in bits 4:0, with brightness bit 4 in byte bit 4, and zeros in bits 7:5.
- R3: Command 0xA9 reads as brightness bits 4..0 in byte bits 7..3, a constant 1 in bit 2, lamp_ok in bit 1 and no_overcurrent in bit 0. A write through 0xA9 takes brightness from data bits 7:3 in the same order.
- R4: Command 0xAA uses the reversed order. Byte bit 7 holds brightness bit 0 and byte bit 3 holds brightness bit 4. Bits 2:0 are the same as for 0xA9, and writes take data bits 7:3 in the same reversed order.
- R5: Command 0x02 writes shutdown mode from data bits 2:0. A read through 0x02 returns it in bits 2:0, with zeros in bits 7:3.
- R6: Command 0x03 is read-only and returns lamp_ok in bit 1, no_overcurrent in bit 0 and zeros elsewhere.
- R7: Command 0xFE reads as 0x4D and command 0xFF reads as 0x0C. Both are read-only.
- R8: A cmd_we strobe loads cmd_byte into the command pointer, and the pointer is visible on the next cycle. When wr_we is high in the same cycle (write-byte), the data goes to the register that cmd_byte addresses. A cmd_we strobe alone (send-byte) changes no data register.
- R9: A rd_req strobe without cmd_we (receive-byte) reads the register that the stored pointer selects. Straight after reset it returns the 0xA9 layout.
- R10: A write to a read-only or unknown command changes neither brightness nor shutdown mode. A read of an unknown command returns 0x00.
- R11: rd_data and rd_valid change on the clock edge after rd_req. rd_valid is high for exactly the cycles that follow a request, and rd_data holds its value when there is no request.
- R12: A wr_we strobe without cmd_we writes the register that the stored pointer selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command byte present this cycle |
| cmd_byte | input | 8 | Command byte |
| wr_we | input | 1 | Data byte write this cycle |
| wr_data | input | 8 | Data byte to write |
| rd_req | input | 1 | Read request this cycle |
| lamp_ok | input | 1 | Lamp-present flag from the fault monitor |
| no_overcurrent | input | 1 | No-overcurrent flag from the fault monitor |
| bright_code | output | 5 | Registered brightness code |
| shdn_mode | output | 3 | Registered shutdown mode |
| cmd_ptr | output | 8 | Stored command pointer |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | rd_data was updated by the previous request |

## Verification
The bound checker checks the following on every cycle:
- The pointer loads and holds as R8 and R9 require.
- The one-cycle read timing and the holding of rd_data match R11.
- Writes to read-only or unknown commands leave the registers untouched.
- Unknown commands read as zero.
- The status and identification bytes read correctly.

Only the bench scenarios can show the following:
- The bit placements of the three brightness views, including the reversed view, and that each view round-trips with the other two.
- The reset layout returned by the first receive-byte.
- Short-protocol sequences such as send-byte followed by a bare data write.

// File: rtl/blr_pkg.sv
package blr_pkg;
  localparam int BR_W = 5;
  localparam int SD_W = 3;
  localparam int BYTE_W = 8;

  localparam logic [7:0] CMD_BR_LOW  = 8'h01;
  localparam logic [7:0] CMD_SHDN    = 8'h02;
  localparam logic [7:0] CMD_STAT    = 8'h03;
  localparam logic [7:0] CMD_BR_LEFT = 8'hA9;
  localparam logic [7:0] CMD_BR_REV  = 8'hAA;
  localparam logic [7:0] CMD_MFG     = 8'hFE;
  localparam logic [7:0] CMD_CHIP    = 8'hFF;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_BR_LOW, SEL_SHDN, SEL_STAT,
    SEL_BR_LEFT, SEL_BR_REV, SEL_MFG, SEL_CHIP
  } sel_e;

  function automatic sel_e decode_cmd(input logic [7:0] c);
    sel_e s;
    case (c)
      CMD_BR_LOW:  s = SEL_BR_LOW;
      CMD_SHDN:    s = SEL_SHDN;
      CMD_STAT:    s = SEL_STAT;
      CMD_BR_LEFT: s = SEL_BR_LEFT;
      CMD_BR_REV:  s = SEL_BR_REV;
      CMD_MFG:     s = SEL_MFG;
      CMD_CHIP:    s = SEL_CHIP;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction

  function automatic logic [BR_W-1:0] rev_bits(input logic [BR_W-1:0] v);
    logic [BR_W-1:0] r;
    for (int i = 0; i < BR_W; i++) r[i] = v[BR_W-1-i];
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_high(input logic [BR_W-1:0] b,
                                                  input logic s1, input logic s0);
    return {b, 1'b1, s1, s0};
  endfunction

  function automatic logic is_bright_sel(input sel_e s);
    return (s == SEL_BR_LOW) || (s == SEL_BR_LEFT) || (s == SEL_BR_REV);
  endfunction
endpackage

// File: rtl/blr_ptr.sv
module blr_ptr #(
  parameter logic [7:0] PTR_RESET = 8'hA9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] value,
  output logic [7:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= PTR_RESET;
    else if (load) ptr <= value;
  end
endmodule

// File: rtl/blr_regs.sv
module blr_regs
  import blr_pkg::*;
#(
  parameter logic [BR_W-1:0] BR_RESET = 5'b10111,
  parameter logic [SD_W-1:0] SD_RESET = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  sel_e              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BR_W-1:0]   bright,
  output logic [SD_W-1:0]   shdn,
  output logic              bright_upd,
  output logic              shdn_upd
);
  localparam int HI_LSB = BYTE_W - BR_W;

  logic [BR_W-1:0] bright_nxt;

  always_comb begin
    case (wr_sel)
      SEL_BR_LEFT: bright_nxt = wr_data[BYTE_W-1:HI_LSB];
      SEL_BR_REV:  bright_nxt = rev_bits(wr_data[BYTE_W-1:HI_LSB]);
      default:     bright_nxt = wr_data[BR_W-1:0];
    endcase
  end

  assign bright_upd = wr_en && is_bright_sel(wr_sel);
  assign shdn_upd   = wr_en && (wr_sel == SEL_SHDN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bright <= BR_RESET;
      shdn   <= SD_RESET;
    end else begin
      if (bright_upd) bright <= bright_nxt;
      if (shdn_upd)   shdn   <= wr_data[SD_W-1:0];
    end
  end
endmodule

// File: rtl/blr_rdmux.sv
module blr_rdmux
  import blr_pkg::*;
#(
  parameter logic [7:0] MFG_ID  = 8'h4D,
  parameter logic [7:0] CHIP_ID = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  sel_e              rd_sel,
  input  logic [BR_W-1:0]   bright,
  input  logic [SD_W-1:0]   shdn,
  input  logic              flag_lamp,
  input  logic              flag_oc,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [BYTE_W-1:0] view;

  always_comb begin
    view = '0;
    case (rd_sel)
      SEL_BR_LOW:  view[BR_W-1:0] = bright;
      SEL_SHDN:    view[SD_W-1:0] = shdn;
      SEL_STAT:    view[1:0] = {flag_lamp, flag_oc};
      SEL_BR_LEFT: view = pack_high(bright, flag_lamp, flag_oc);
      SEL_BR_REV:  view = pack_high(rev_bits(bright), flag_lamp, flag_oc);
      SEL_MFG:     view = MFG_ID;
      SEL_CHIP:    view = CHIP_ID;
      default:     view = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= view;
    end
  end
endmodule

// File: rtl/blr_top.sv
module blr_top
  import blr_pkg::*;
#(
  parameter logic [7:0]      PTR_RESET = 8'hA9,
  parameter logic [BR_W-1:0] BR_RESET  = 5'b10111,
  parameter logic [SD_W-1:0] SD_RESET  = 3'b001,
  parameter logic [7:0]      MFG_ID    = 8'h4D,
  parameter logic [7:0]      CHIP_ID   = 8'h0C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_byte,
  input  logic       wr_we,
  input  logic [7:0] wr_data,
  input  logic       rd_req,
  input  logic       lamp_ok,
  input  logic       no_overcurrent,
  output logic [4:0] bright_code,
  output logic [2:0] shdn_mode,
  output logic [7:0] cmd_ptr,
  output logic [7:0] rd_data,
  output logic       rd_valid
);
  // Internal events brought out by name for the checker
  logic [7:0] acc_cmd;
  sel_e       acc_sel;
  logic       bright_upd;
  logic       shdn_upd;

  // A command phase in the same cycle takes priority over the stored pointer
  assign acc_cmd = cmd_we ? cmd_byte : cmd_ptr;
  assign acc_sel = decode_cmd(acc_cmd);

  blr_ptr #(.PTR_RESET(PTR_RESET)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(cmd_we), .value(cmd_byte), .ptr(cmd_ptr)
  );

  blr_regs #(.BR_RESET(BR_RESET), .SD_RESET(SD_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_we), .wr_sel(acc_sel), .wr_data(wr_data),
    .bright(bright_code), .shdn(shdn_mode),
    .bright_upd(bright_upd), .shdn_upd(shdn_upd)
  );

  blr_rdmux #(.MFG_ID(MFG_ID), .CHIP_ID(CHIP_ID)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_req), .rd_sel(acc_sel),
    .bright(bright_code), .shdn(shdn_mode),
    .flag_lamp(lamp_ok), .flag_oc(no_overcurrent),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/blr_chk.sv
module blr_chk
  import blr_pkg::*;
#(
  parameter logic [7:0] MFG_ID  = 8'h4D,
  parameter logic [7:0] CHIP_ID = 8'h0C
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic [7:0] cmd_byte,
  input logic       wr_we,
  input logic       rd_req,
  input logic       lamp_ok,
  input logic       no_overcurrent,
  input logic [4:0] bright_code,
  input logic [2:0] shdn_mode,
  input logic [7:0] cmd_ptr,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input sel_e       acc_sel,
  input logic       bright_upd,
  input logic       shdn_upd
);
  logic ro_target;
  assign ro_target = (acc_sel == SEL_NONE) || (acc_sel == SEL_STAT) ||
                     (acc_sel == SEL_MFG) || (acc_sel == SEL_CHIP);

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> cmd_ptr == $past(cmd_byte)); // R8
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(cmd_ptr)); // R9
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid); // R11
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid && $stable(rd_data)); // R11
  AST_BR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bright_upd |=> $stable(bright_code)); // R10
  AST_SD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_upd |=> $stable(shdn_mode)); // R10
  AST_RO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_we && ro_target) |=> $stable(bright_code) && $stable(shdn_mode)); // R10
  AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && acc_sel == SEL_NONE) |=> rd_data == 8'h00); // R10
  AST_MFG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && acc_sel == SEL_MFG) |=> rd_data == MFG_ID); // R7
  AST_CHIP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && acc_sel == SEL_CHIP) |=> rd_data == CHIP_ID); // R7
  AST_STAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && acc_sel == SEL_STAT) |=>
      rd_data == {6'b0, $past(lamp_ok), $past(no_overcurrent)}); // R6
endmodule

bind blr_top blr_chk #(.MFG_ID(MFG_ID), .CHIP_ID(CHIP_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
  .wr_we(wr_we), .rd_req(rd_req), .lamp_ok(lamp_ok),
  .no_overcurrent(no_overcurrent), .bright_code(bright_code),
  .shdn_mode(shdn_mode), .cmd_ptr(cmd_ptr), .rd_data(rd_data),
  .rd_valid(rd_valid), .acc_sel(acc_sel), .bright_upd(bright_upd),
  .shdn_upd(shdn_upd)
);

// File: tb/test_blr_top.sv
module test_blr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       wr_we = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_req = 1'b0;
  logic       lamp_ok = 1'b1;
  logic       no_overcurrent = 1'b1;
  logic [4:0] bright_code;
  logic [2:0] shdn_mode;
  logic [7:0] cmd_ptr;
  logic [7:0] rd_data;
  logic       rd_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] val; string req; } exp_t;
  exp_t sb_q[$];

  // Bench model state
  logic [4:0] m_br = 5'b10111;
  logic [2:0] m_sd = 3'b001;
  logic [7:0] m_ptr = 8'hA9;

  always #10 clk = ~clk; // 50 MHz

  blr_top i_blr_top (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .wr_we(wr_we), .wr_data(wr_data), .rd_req(rd_req), .lamp_ok(lamp_ok),
    .no_overcurrent(no_overcurrent), .bright_code(bright_code),
    .shdn_mode(shdn_mode), .cmd_ptr(cmd_ptr), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected byte from the requirement tables
  function automatic logic [7:0] model_read(input logic [7:0] c);
    logic [7:0] b;
    b = 8'h00;
    if (c == 8'h01) b = {3'b000, m_br};
    else if (c == 8'h02) b = {5'b00000, m_sd};
    else if (c == 8'h03) b = {6'b0, lamp_ok, no_overcurrent};
    else if (c == 8'hA9) b = {m_br[4], m_br[3], m_br[2], m_br[1], m_br[0], 1'b1, lamp_ok, no_overcurrent};
    else if (c == 8'hAA) b = {m_br[0], m_br[1], m_br[2], m_br[3], m_br[4], 1'b1, lamp_ok, no_overcurrent};
    else if (c == 8'hFE) b = 8'h4D;
    else if (c == 8'hFF) b = 8'h0C;
    return b;
  endfunction

  function automatic void model_write(input logic [7:0] c, input logic [7:0] d);
    if (c == 8'h01) m_br = d[4:0];
    else if (c == 8'h02) m_sd = d[2:0];
    else if (c == 8'hA9) m_br = d[7:3];
    else if (c == 8'hAA) m_br = {d[3], d[4], d[5], d[6], d[7]};
  endfunction

  // Driver: one transaction cycle, expected read pushed to the scoreboard
  task automatic xact(input bit c, input logic [7:0] cb, input bit w,
                      input logic [7:0] wd, input bit r, input string req);
    logic [7:0] tgt;
    @(negedge clk);
    cmd_we = c; cmd_byte = cb; wr_we = w; wr_data = wd; rd_req = r;
    tgt = c ? cb : m_ptr;
    if (r) sb_q.push_back('{model_read(tgt), req});
    if (c) m_ptr = cb;
    if (w) model_write(tgt, wd);
    @(negedge clk);
    cmd_we = 1'b0; wr_we = 1'b0; rd_req = 1'b0;
  endtask

  // Monitor: pops on every returned read
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R11 unexpected rd_valid actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, {24'b0, rd_data}, {24'b0, e.val});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 bright", {27'b0, bright_code}, 32'h17);
    check("R1 shdn", {29'b0, shdn_mode}, 32'h1);
    check("R1 ptr", {24'b0, cmd_ptr}, 32'hA9);
    check("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 receive-byte straight after reset, R3 layout
    xact(0, 8'h00, 0, 8'h00, 1, "R9 reset receive-byte");
    // R2 write-byte through 0x01, R8 pointer
    xact(1, 8'h01, 1, 8'hE5, 0, "R2");
    check("R2 bright", {27'b0, bright_code}, {27'b0, m_br});
    check("R8 ptr", {24'b0, cmd_ptr}, 32'h01);
    xact(0, 8'h00, 0, 8'h00, 1, "R2 receive low view");
    // R3 left-justified view with mixed flags
    xact(1, 8'hA9, 1, 8'b1100_1010, 0, "R3");
    check("R3 bright", {27'b0, bright_code}, 32'h19);
    lamp_ok = 1'b0;
    xact(1, 8'hA9, 0, 8'h00, 1, "R3 read");
    xact(1, 8'h01, 0, 8'h00, 1, "R2 cross view");
    // R4 reversed view
    lamp_ok = 1'b1; no_overcurrent = 1'b0;
    xact(1, 8'hAA, 1, 8'b1000_0111, 0, "R4");
    check("R4 bright", {27'b0, bright_code}, 32'h01);
    xact(1, 8'hAA, 0, 8'h00, 1, "R4 read");
    xact(1, 8'hA9, 0, 8'h00, 1, "R3 cross view");
    xact(1, 8'hAA, 1, 8'b0110_1000, 0, "R4 asym");
    xact(1, 8'h01, 0, 8'h00, 1, "R4 asym via low");
    // R5 shutdown mode
    xact(1, 8'h02, 1, 8'hFE, 0, "R5");
    check("R5 shdn", {29'b0, shdn_mode}, 32'h6);
    xact(0, 8'h00, 0, 8'h00, 1, "R5 read");
    // R6 status
    xact(1, 8'h03, 0, 8'h00, 1, "R6 read a");
    lamp_ok = 1'b0; no_overcurrent = 1'b1;
    xact(0, 8'h00, 0, 8'h00, 1, "R6 read b");
    // R7 IDs, R10 ignored writes
    xact(1, 8'hFE, 1, 8'h00, 1, "R7 mfg");
    xact(1, 8'hFF, 1, 8'hFF, 1, "R7 chip");
    xact(1, 8'h03, 1, 8'h07, 0, "R10");
    check("R10 bright kept", {27'b0, bright_code}, {27'b0, m_br});
    check("R10 shdn kept", {29'b0, shdn_mode}, 32'h6);
    xact(1, 8'h55, 1, 8'h1F, 1, "R10 unknown read");
    check("R10 bright after unknown", {27'b0, bright_code}, {27'b0, m_br});
    // R8 send-byte, then R12 bare data write
    xact(1, 8'h02, 0, 8'h00, 0, "R8");
    check("R8 send-byte shdn", {29'b0, shdn_mode}, 32'h6);
    check("R8 send-byte ptr", {24'b0, cmd_ptr}, 32'h02);
    xact(0, 8'h00, 1, 8'h03, 0, "R12");
    check("R12 shdn", {29'b0, shdn_mode}, 32'h3);
    xact(0, 8'h00, 0, 8'h00, 1, "R12 readback");
    // R11 idle keeps rd_valid low and rd_data held
    @(negedge clk);
    check("R11 rd_valid idle", {31'b0, rd_valid}, 32'h0);
    check("R11 rd_data held", {24'b0, rd_data}, 32'h03);
    check("R11 scoreboard drained", sb_q.size(), 32'h0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule